// File: doc/BRIEF.md
# Dual-Bank Read-While-Write Mode Tracker

This block sits in the command path of a two-bank flash-style memory. It keeps, for each bank, a read mode (array data, operation status, or identification/protection data) and an operation state (idle, programming, erasing, erase suspended, or programming inside a suspended erase). Decoded commands arrive together with their latched word address. Two done pulses, one per bank, stand in for the write state machine that would finish each program or erase.

Starting a program, an erase or an erase resume in one bank puts that bank into status mode and forces the other bank back to array mode. This lets the idle bank be read while the busy one works. A read address is decoded to a bank, and the block reports what that read returns and the busy/suspended status of that bank. Identification reads are gated by a boot-orientation strap and by the state of the banks. A refused command raises a one-cycle error flag.

Top module: `rww_mode_tracker`

## Requirements
- R1: After reset both banks are idle, not suspended, and in array mode (rd_src=0). cmd_err is 0.
- R2: An accepted program (cmd_op=1), erase (cmd_op=2) or erase resume (cmd_op=4) changes the state by the next clock edge. The addressed bank then reads status (rd_src=1) and the other bank reads array (rd_src=0).
- R3: The read bank is 1 when rd_addr is at or above the split address, which defaults to bit 20 set. rd_src gives the addressed bank's mode: 0 array, 1 status, 2 identification. rd_stat gives {running, suspended} for that bank.
- R4: A program or erase is refused when the other bank is not idle or the target bank is not idle. The one exception is the program allowed by R5. A refused command pulses cmd_err in the cycle after it and changes no state.
- R5: A suspend command (cmd_op=3) during an erase makes the bank suspended (rd_stat=01). A program there to a different block, where the block is address bits [20:15], is accepted (rd_stat=11). A program to the block being erased is refused with cmd_err.
- R6: A done pulse ends a program or an erase, leaving the bank idle, or returns a program-in-suspend to the suspended state. The bank keeps reading status until a read-array command arrives.
- R7: A resume while the bank is suspended and not programming restarts the erase. A resume in any other state is ignored, with no error.
- R8: With boot_top=0, an identification read (cmd_op=6) is accepted only if bank b is in array mode and bank a is not running. It then puts the addressed bank in identification mode. Otherwise it pulses cmd_err and changes nothing.
- R9: With boot_top=1, an identification read is accepted only if bank a is in array mode and neither bank is running. Otherwise it pulses cmd_err and changes nothing.
- R10: A read-array command (cmd_op=5) sets the addressed bank to array mode in any operation state. cmd_op 0 and 7 have no effect.
- R11: boot_top_o always equals boot_top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_op | input | 3 | Decoded command code, 0 means none |
| cmd_addr | input | 21 | Latched word address of the command |
| done_a | input | 1 | Operation-complete pulse for bank a |
| done_b | input | 1 | Operation-complete pulse for bank b |
| boot_top | input | 1 | Boot orientation strap, 1 for top boot |
| rd_addr | input | 21 | Word address of the current read |
| rd_bank | output | 1 | Bank addressed by the read, 0 for a |
| rd_src | output | 2 | What the read returns: array, status or identification |
| rd_stat | output | 2 | {running, suspended} of the addressed bank |
| cmd_err | output | 1 | Previous command was refused |
| boot_top_o | output | 1 | Copy of the boot strap |

## Verification
Directed sequences cover the following cases:
- Programming one bank and then reading both banks, which shows that the status/array split follows the addressed bank.
- An erase-suspend-program-resume chain that targets both the erased block and a different block, which shows the block compare at work.
- Identification reads under each strap value with a busy bank a, a busy bank b, and a suspended bank, which separates the two gating rules.

Seeded random command streams then mix all command codes, including the unused one, with done pulses on both banks and flips of the strap. These streams reach refused and ignored commands in states the directed cases do not visit.

// File: rtl/rww_pkg.sv
package rww_pkg;

    localparam logic [2:0] CMD_NOP    = 3'd0;
    localparam logic [2:0] CMD_PROG   = 3'd1;
    localparam logic [2:0] CMD_ERASE  = 3'd2;
    localparam logic [2:0] CMD_SUSP   = 3'd3;
    localparam logic [2:0] CMD_RESUME = 3'd4;
    localparam logic [2:0] CMD_RDARR  = 3'd5;
    localparam logic [2:0] CMD_RDID   = 3'd6;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_ID     = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_SUSP  = 3'd3,
        OP_PSUSP = 3'd4
    } op_e;

endpackage

// File: rtl/rww_bank.sv
module rww_bank
    import rww_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_op,
    input  logic             here,
    input  logic [BLK_W-1:0] blk,
    input  logic             other_idle,
    input  logic             other_start,
    input  logic             id_ok,
    input  logic             done,
    output mode_e            mode,
    output logic             running,
    output logic             suspended,
    output logic             idle,
    output logic             start,
    output logic             reject
);

    typedef struct packed {
        mode_e            mode;
        op_e              op;
        logic [BLK_W-1:0] sblk;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        start  = 1'b0;
        reject = 1'b0;
        if (done) begin
            case (st_q.op)
                OP_PROG, OP_ERASE: st_d.op = OP_IDLE;
                OP_PSUSP:          st_d.op = OP_SUSP;
                default:           ;
            endcase
        end
        if (other_start) st_d.mode = MD_ARRAY;
        if (here) begin
            case (cmd_op)
                CMD_PROG: begin
                    if (st_q.op == OP_IDLE && other_idle) begin
                        st_d.op = OP_PROG;
                        start   = 1'b1;
                    end else if (st_q.op == OP_SUSP && other_idle && blk != st_q.sblk) begin
                        st_d.op = OP_PSUSP;
                        start   = 1'b1;
                    end else begin
                        reject = 1'b1;
                    end
                end
                CMD_ERASE: begin
                    if (st_q.op == OP_IDLE && other_idle) begin
                        st_d.op   = OP_ERASE;
                        st_d.sblk = blk;
                        start     = 1'b1;
                    end else begin
                        reject = 1'b1;
                    end
                end
                CMD_SUSP: begin
                    if (st_q.op == OP_ERASE) st_d.op = OP_SUSP;
                end
                CMD_RESUME: begin
                    if (st_q.op == OP_SUSP) begin
                        st_d.op = OP_ERASE;
                        start   = 1'b1;
                    end
                end
                CMD_RDARR: st_d.mode = MD_ARRAY;
                CMD_RDID: begin
                    if (id_ok) st_d.mode = MD_ID;
                    else       reject    = 1'b1;
                end
                default: ;
            endcase
            if (start) st_d.mode = MD_STATUS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_ARRAY, op: OP_IDLE, sblk: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode      = st_q.mode;
    assign running   = (st_q.op == OP_PROG) || (st_q.op == OP_ERASE) || (st_q.op == OP_PSUSP);
    assign suspended = (st_q.op == OP_SUSP) || (st_q.op == OP_PSUSP);
    assign idle      = (st_q.op == OP_IDLE);

    assert_start_to_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.mode == MD_STATUS));

    assert_forced_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
        other_start |=> (st_q.mode == MD_ARRAY));

    assert_erased_block_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (here && cmd_op == CMD_PROG && st_q.op == OP_SUSP && blk == st_q.sblk)
        |=> (st_q.op == OP_SUSP));

    assert_done_keeps_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_op == CMD_NOP && st_q.op == OP_PROG && !other_start)
        |=> (st_q.op == OP_IDLE) && $stable(st_q.mode));

    assert_stray_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (here && cmd_op == CMD_RESUME && st_q.op != OP_SUSP && !done)
        |=> $stable(st_q.op));

endmodule

// File: rtl/rww_rd_sel.sv
module rww_rd_sel
    import rww_pkg::*;
#(
    parameter int              ADDR_W = 21,
    parameter logic [ADDR_W-1:0] SPLIT = ADDR_W'(1) << (ADDR_W - 1)
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  mode_e             mode_a,
    input  mode_e             mode_b,
    input  logic [1:0]        run,
    input  logic [1:0]        susp,
    output logic              rd_bank,
    output logic [1:0]        rd_src,
    output logic [1:0]        rd_stat
);

    always_comb begin
        rd_bank = (rd_addr >= SPLIT);
        rd_src  = rd_bank ? mode_b : mode_a;
        rd_stat = rd_bank ? {run[1], susp[1]} : {run[0], susp[0]};
    end

endmodule

// File: rtl/rww_mode_tracker.sv
module rww_mode_tracker
    import rww_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int BLK_LSB = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              done_a,
    input  logic              done_b,
    input  logic              boot_top,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bank,
    output logic [1:0]        rd_src,
    output logic [1:0]        rd_stat,
    output logic              cmd_err,
    output logic              boot_top_o
);

    localparam int                BLK_W = ADDR_W - BLK_LSB;
    localparam logic [ADDR_W-1:0] SPLIT = ADDR_W'(1) << (ADDR_W - 1);

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t    top_d, top_q;
    logic [1:0] here, start, reject, run, susp, idle_v, done_v;
    logic       id_ok;
    mode_e      mode_v [2];
    logic [BLK_W-1:0] blk;

    assign blk    = cmd_addr[ADDR_W-1:BLK_LSB];
    assign done_v = {done_b, done_a};

    always_comb begin
        here = (cmd_addr >= SPLIT) ? 2'b10 : 2'b01;
        if (boot_top) id_ok = (mode_v[0] == MD_ARRAY) && !run[0] && !run[1];
        else          id_ok = (mode_v[1] == MD_ARRAY) && !run[0];
        top_d.err = |reject;
    end

    for (genvar i = 0; i < 2; i++) begin : g_bank
        rww_bank #(.BLK_W(BLK_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_op     (cmd_op),
            .here       (here[i]),
            .blk        (blk),
            .other_idle (idle_v[1-i]),
            .other_start(start[1-i]),
            .id_ok      (id_ok),
            .done       (done_v[i]),
            .mode       (mode_v[i]),
            .running    (run[i]),
            .suspended  (susp[i]),
            .idle       (idle_v[i]),
            .start      (start[i]),
            .reject     (reject[i])
        );
    end

    rww_rd_sel #(.ADDR_W(ADDR_W), .SPLIT(SPLIT)) u_rd_sel (
        .rd_addr(rd_addr),
        .mode_a (mode_v[0]),
        .mode_b (mode_v[1]),
        .run    (run),
        .susp   (susp),
        .rd_bank(rd_bank),
        .rd_src (rd_src),
        .rd_stat(rd_stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{err: 1'b0};
        else        top_q <= top_d;
    end

    assign cmd_err    = top_q.err;
    assign boot_top_o = boot_top;

    assert_one_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(run[0] && run[1]));

    assert_id_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_RDID && !id_ok) |=> cmd_err);

    assert_id_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_RDID && !id_ok && done_v == 2'b00)
        |=> $stable(run) && $stable(susp));

endmodule

// File: tb/rww_mode_tracker_tb.sv
`timescale 1ns/100ps
module rww_mode_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [20:0] cmd_addr = '0;
    logic        done_a = 1'b0, done_b = 1'b0, boot_top = 1'b0;
    logic [20:0] rd_addr = '0;
    logic        rd_bank, cmd_err, boot_top_o;
    logic [1:0]  rd_src, rd_stat;

    int total = 0, bad = 0;
    bit finished = 0;
    int m_mode [2];
    int m_op [2];
    int m_sblk [2];
    bit m_err;

    always #2.5 clk = ~clk;

    rww_mode_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .done_a(done_a), .done_b(done_b), .boot_top(boot_top), .rd_addr(rd_addr),
        .rd_bank(rd_bank), .rd_src(rd_src), .rd_stat(rd_stat),
        .cmd_err(cmd_err), .boot_top_o(boot_top_o)
    );

    function automatic logic [20:0] mk(int bank, int blk, int off);
        return {bank[0], blk[4:0], off[14:0]};
    endfunction

    function automatic bit is_run(int o);
        return (o == 1) || (o == 2) || (o == 4);
    endfunction

    function automatic int exp_stat(int o);
        return (is_run(o) ? 2 : 0) + (((o == 3) || (o == 4)) ? 1 : 0);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model(int op, logic [20:0] a, bit da, bit db, bit top);
        int b = a[20] ? 1 : 0;
        int k = 1 - b;
        int blk = int'(a[20:15]);
        int nm [2];
        int no [2];
        int ns [2];
        bit ok;
        nm = m_mode; no = m_op; ns = m_sblk;
        m_err = 0;
        if (da) begin if (m_op[0] == 1 || m_op[0] == 2) no[0] = 0; else if (m_op[0] == 4) no[0] = 3; end
        if (db) begin if (m_op[1] == 1 || m_op[1] == 2) no[1] = 0; else if (m_op[1] == 4) no[1] = 3; end
        case (op)
            1: begin
                if (m_op[b] == 0 && m_op[k] == 0) begin no[b] = 1; nm[b] = 1; nm[k] = 0; end
                else if (m_op[b] == 3 && m_op[k] == 0 && blk != m_sblk[b]) begin no[b] = 4; nm[b] = 1; nm[k] = 0; end
                else m_err = 1;
            end
            2: begin
                if (m_op[b] == 0 && m_op[k] == 0) begin no[b] = 2; ns[b] = blk; nm[b] = 1; nm[k] = 0; end
                else m_err = 1;
            end
            3: if (m_op[b] == 2) no[b] = 3;
            4: if (m_op[b] == 3) begin no[b] = 2; nm[b] = 1; nm[k] = 0; end
            5: nm[b] = 0;
            6: begin
                if (top) ok = (m_mode[0] == 0) && !is_run(m_op[0]) && !is_run(m_op[1]);
                else     ok = (m_mode[1] == 0) && !is_run(m_op[0]);
                if (ok) nm[b] = 2; else m_err = 1;
            end
            default: ;
        endcase
        m_mode = nm; m_op = no; m_sblk = ns;
    endtask

    // drive at the current negedge, check at the following negedge
    task automatic step(string tag, int op, logic [20:0] a, bit da, bit db);
        cmd_op = op[2:0]; cmd_addr = a; done_a = da; done_b = db;
        model(op, a, da, db, boot_top);
        @(posedge clk);
        @(negedge clk);
        cmd_op = 3'd0; done_a = 1'b0; done_b = 1'b0;
        #0.2;
        chk(tag, "cmd_err", int'(cmd_err), int'(m_err));
        chk("R11", "boot_top_o", int'(boot_top_o), int'(boot_top));
        rd_addr = mk(0, 3, 17);
        #0.3;
        chk("R3", "rd_bank a", int'(rd_bank), 0);
        chk(tag, "rd_src a", int'(rd_src), m_mode[0]);
        chk(tag, "rd_stat a", int'(rd_stat), exp_stat(m_op[0]));
        rd_addr = mk(1, 2, 5);
        #0.3;
        chk("R3", "rd_bank b", int'(rd_bank), 1);
        chk(tag, "rd_src b", int'(rd_src), m_mode[1]);
        chk(tag, "rd_stat b", int'(rd_stat), exp_stat(m_op[1]));
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        m_mode = '{0, 0}; m_op = '{0, 0}; m_sblk = '{0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_addr = mk(0, 0, 0); #0.5;
        chk("R1", "reset src a", int'(rd_src), 0);
        chk("R1", "reset stat a", int'(rd_stat), 0);
        chk("R1", "reset err", int'(cmd_err), 0);
        rd_addr = mk(1, 0, 0); #0.5;
        chk("R1", "reset src b", int'(rd_src), 0);
        @(negedge clk);

        // R2 program in a, R8 bottom-boot ID read blocked while a runs
        step("R2", 1, mk(0, 1, 0), 0, 0);
        step("R4", 2, mk(1, 1, 0), 0, 0);
        step("R8", 6, mk(1, 0, 0), 0, 0);
        step("R6", 0, 0, 1, 0);
        step("R10", 5, mk(0, 0, 0), 0, 0);
        // R5 erase/suspend/program chain in b
        step("R2", 2, mk(1, 4, 0), 0, 0);
        step("R7", 4, mk(1, 4, 0), 0, 0);
        step("R5", 3, mk(1, 4, 0), 0, 0);
        step("R5", 1, mk(1, 4, 9), 0, 0);
        step("R5", 1, mk(1, 6, 9), 0, 0);
        step("R7", 4, mk(1, 4, 0), 0, 0);
        step("R6", 0, 0, 0, 1);
        step("R8", 6, mk(0, 0, 0), 0, 0);
        step("R10", 5, mk(1, 0, 0), 0, 0);
        step("R8", 6, mk(0, 0, 0), 0, 0);
        step("R7", 4, mk(1, 0, 0), 0, 0);
        step("R6", 0, 0, 0, 1);
        step("R10", 5, mk(0, 0, 0), 0, 0);
        // R9 top boot: concurrency blocks ID reads
        boot_top = 1'b1;
        step("R9", 6, mk(1, 0, 0), 0, 0);
        step("R10", 5, mk(1, 0, 0), 0, 0);
        step("R2", 1, mk(1, 1, 0), 0, 0);
        step("R9", 6, mk(0, 0, 0), 0, 0);
        step("R6", 0, 0, 0, 1);
        step("R9", 6, mk(0, 0, 0), 0, 0);
        step("R10", 7, mk(0, 0, 0), 0, 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(0, 7);
            int bk = $urandom_range(0, 1);
            int bl = $urandom_range(0, 2);
            bit da = 0, db = 0;
            if (n % 500 == 499) boot_top = ~boot_top;
            if (op == 0 && $urandom_range(0, 1) == 1) begin
                da = $urandom_range(0, 1) == 1;
                db = !da;
            end
            step("R4", op, mk(bk, bl, $urandom_range(0, 32767)), da, db);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule